// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block sits on the host side of an 8-channel, 8-bit successive-approximation converter that has a byte-wide parallel port. When a conversion is requested, the sequencer pulls the active-low convert-start line. It then waits for the end-of-conversion strobe, or gives up when a cycle budget runs out. After that it runs a chip-select/read cycle that fetches the result byte. The same read cycle presents the multiplexer address that the converter uses for its next conversion.

Results leave through a valid/ready port. Each result carries the channel it was converted from. That channel is the address that went out during the previous read, or channel 0 for the first result after reset.

The converter's power mode is set by the level of convert-start at the moment the conversion ends. In normal mode the sequencer raises convert-start after a fixed pulse. In power-down mode it holds convert-start low until end-of-conversion arrives. The channel comes either from a direct input or from a built-in scan that steps through 0 to 7 and wraps.

Top module: `adc_seq`

## Requirements
- R1: After reset, `convst_n_o`, `cs_n_o` and `rd_n_o` are high, `res_valid_o` and `err_o` are low, and `addr_o` is 0.
- R2: When idle, with no result pending and the acquisition window satisfied, a high `req_i` sampled at a clock edge drives `convst_n_o` low at that same edge.
- R3: Two successive falling edges of `convst_n_o` are at least `ACQ_CYC` clock cycles apart.
- R4: With `pwrdn_i` low at the start, `convst_n_o` stays low for exactly `CONV_LOW_CYC` cycles and then returns high.
- R5: With `pwrdn_i` high at the start, `convst_n_o` stays low until `eoc_n_i` is sampled low, and it goes high at that same edge.
- R6: At the edge where `eoc_n_i` is sampled low, `cs_n_o` falls and the next address appears on `addr_o` while `rd_n_o` stays high. `rd_n_o` falls one cycle later and stays low for `RD_LOW_CYC` cycles. `cs_n_o` and `rd_n_o` then rise at the same edge. `addr_o` does not change while `rd_n_o` is low.
- R7: The result byte is the value on `data_i` at the edge one cycle before `rd_n_o` rises. Bus values at any other time do not affect the result.
- R8: With `scan_i` low, the next address is `chan_i`. With `scan_i` high, it is the current conversion channel plus one, modulo 8, so 7 is followed by 0.
- R9: `res_chan_o` is the address presented during the previous read cycle, or 0 for the first conversion after reset.
- R10: `res_valid_o` rises at the edge where `cs_n_o` and `rd_n_o` rise. While `res_valid_o` is high and `res_ready_i` is low, `res_valid_o`, `res_data_o` and `res_chan_o` hold. `res_valid_o` falls at the edge where it is sampled with `res_ready_i` high.
- R11: If `eoc_n_i` is not sampled low within `TIMEOUT_CYC` cycles of the start, then at edge `TIMEOUT_CYC` after the start `err_o` rises and `convst_n_o` goes high. No read cycle and no result follow. `err_o` clears at the next start.
- R12: No conversion starts while a result is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Conversion request (level) |
| pwrdn_i | input | 1 | Mode for this conversion: 1 = power-down, 0 = normal |
| scan_i | input | 1 | 1 = next address is current + 1, 0 = use `chan_i` |
| chan_i | input | 3 | Direct next-channel address |
| convst_n_o | output | 1 | Convert-start, active low |
| eoc_n_i | input | 1 | End of conversion, active low, synchronous to `clk_i` |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| addr_o | output | 3 | Multiplexer address for the next conversion |
| data_i | input | 8 | Converter data bus |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result ready |
| res_data_o | output | 8 | Result byte |
| res_chan_o | output | 3 | Channel the result was converted from |
| err_o | output | 1 | End-of-conversion timeout flag |

## Verification
The bench drives a different byte on the bus during the last read-low cycle, so a design that samples at the rising edge of read returns the wrong byte. It requests a new conversion right after each result, so a sequencer that ignores the acquisition window produces starts closer together than `ACQ_CYC`. A scan run passes channel 7, so an address counter that saturates or skips the wrap shows up on `addr_o` and on the channel tags. Other directed cases cover the following faults:
- withholding end-of-conversion, which catches a missing or late timeout;
- leaving a result unconsumed, which catches a design that overwrites it;
- power-down conversions, which catch a design that releases convert-start early.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SETUP, ST_READ} seq_state_e;

  function automatic int cnt_w(input int n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/adc_seq_cnt.sv
module adc_seq_cnt #(
  parameter int MAX = 4,
  localparam int W = adc_seq_pkg::cnt_w(MAX)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  localparam logic [W-1:0] TOP = W'(MAX - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= TOP;
    else if (en_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan #(
  parameter int CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            latch_i,
  input  logic            commit_i,
  input  logic            scan_i,
  input  logic [CH_W-1:0] chan_i,
  output logic [CH_W-1:0] addr_o,
  output logic [CH_W-1:0] cur_o
);
  logic [CH_W-1:0] addr_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cur_q  <= '0;
    end else begin
      if (latch_i)  addr_q <= scan_i ? cur_q + 1'b1 : chan_i;
      if (commit_i) cur_q  <= addr_q;
    end
  end

  assign addr_o = addr_q;
  assign cur_o  = cur_q;

  a_r8_scan_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && scan_i && cur_o == '1) |=> (addr_o == '0));
  a_r8_direct_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !scan_i) |=> (addr_o == $past(chan_i)));
endmodule

// File: rtl/adc_seq_out.sv
module adc_seq_out #(
  parameter int DW   = 8,
  parameter int CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [DW-1:0]   data_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [DW-1:0]   data_o,
  output logic [CH_W-1:0] chan_o
);
  logic            valid_q;
  logic [DW-1:0]   data_q;
  logic [CH_W-1:0] chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      chan_q  <= '0;
    end else if (push_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
      chan_q  <= chan_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign chan_o  = chan_q;

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(chan_o)));
  a_r12_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !valid_o);
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DW           = 8,
  parameter int CH_W         = 3,
  parameter int CONV_LOW_CYC = 4,
  parameter int ACQ_CYC      = 24,
  parameter int RD_LOW_CYC   = 3,   // must be >= 2
  parameter int TIMEOUT_CYC  = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            pwrdn_i,
  input  logic            scan_i,
  input  logic [CH_W-1:0] chan_i,
  output logic            convst_n_o,
  input  logic            eoc_n_i,
  output logic            cs_n_o,
  output logic            rd_n_o,
  output logic [CH_W-1:0] addr_o,
  input  logic [DW-1:0]   data_i,
  output logic            res_valid_o,
  input  logic            res_ready_i,
  output logic [DW-1:0]   res_data_o,
  output logic [CH_W-1:0] res_chan_o,
  output logic            err_o
);
  import adc_seq_pkg::*;

  localparam int RD_W = cnt_w(RD_LOW_CYC);

  seq_state_e      st_q;
  logic            convst_q, cs_q, rd_q, mode_q, err_q;
  logic [DW-1:0]   cap_q;
  logic [CH_W-1:0] cur_ch;
  logic            acq_zero, pulse_zero, wd_zero, rd_zero;
  logic [RD_W-1:0] rd_cnt;
  logic            start, eoc_hit, tmo, cap, done;

  logic [cnt_w(ACQ_CYC)-1:0]      acq_cnt_unused;
  logic [cnt_w(CONV_LOW_CYC)-1:0] pulse_cnt_unused;
  logic [cnt_w(TIMEOUT_CYC)-1:0]  wd_cnt_unused;

  assign start   = (st_q == ST_IDLE) && req_i && acq_zero && !res_valid_o;
  assign eoc_hit = (st_q == ST_WAIT) && !eoc_n_i;
  assign tmo     = (st_q == ST_WAIT) && eoc_n_i && wd_zero;
  assign cap     = (st_q == ST_READ) && (rd_cnt == RD_W'(1));
  assign done    = (st_q == ST_READ) && rd_zero;

  adc_seq_cnt #(.MAX(ACQ_CYC)) u_acq (
    .clk_i, .rst_ni, .load_i(start), .en_i(1'b1),
    .cnt_o(acq_cnt_unused), .zero_o(acq_zero));

  adc_seq_cnt #(.MAX(CONV_LOW_CYC)) u_pulse (
    .clk_i, .rst_ni, .load_i(start), .en_i(1'b1),
    .cnt_o(pulse_cnt_unused), .zero_o(pulse_zero));

  adc_seq_cnt #(.MAX(TIMEOUT_CYC)) u_wd (
    .clk_i, .rst_ni, .load_i(start), .en_i(st_q == ST_WAIT),
    .cnt_o(wd_cnt_unused), .zero_o(wd_zero));

  adc_seq_cnt #(.MAX(RD_LOW_CYC)) u_rd (
    .clk_i, .rst_ni, .load_i(st_q == ST_SETUP), .en_i(st_q == ST_READ),
    .cnt_o(rd_cnt), .zero_o(rd_zero));

  adc_seq_chan #(.CH_W(CH_W)) u_chan (
    .clk_i, .rst_ni, .latch_i(eoc_hit), .commit_i(done),
    .scan_i, .chan_i, .addr_o, .cur_o(cur_ch));

  adc_seq_out #(.DW(DW), .CH_W(CH_W)) u_out (
    .clk_i, .rst_ni, .push_i(done), .data_i(cap_q), .chan_i(cur_ch),
    .ready_i(res_ready_i), .valid_o(res_valid_o), .data_o(res_data_o),
    .chan_o(res_chan_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      convst_q <= 1'b1;
      cs_q     <= 1'b1;
      rd_q     <= 1'b1;
      mode_q   <= 1'b0;
      err_q    <= 1'b0;
      cap_q    <= '0;
    end else begin
      if (cap) cap_q <= data_i;
      unique case (st_q)
        ST_IDLE: if (start) begin
          convst_q <= 1'b0;
          mode_q   <= pwrdn_i;
          err_q    <= 1'b0;
          st_q     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (eoc_hit) begin
            convst_q <= 1'b1;
            cs_q     <= 1'b0;
            st_q     <= ST_SETUP;
          end else if (tmo) begin
            convst_q <= 1'b1;
            err_q    <= 1'b1;
            st_q     <= ST_IDLE;
          end else if (!mode_q && pulse_zero) begin
            convst_q <= 1'b1;
          end
        end
        ST_SETUP: begin
          rd_q <= 1'b0;
          st_q <= ST_READ;
        end
        ST_READ: if (done) begin
          rd_q <= 1'b1;
          cs_q <= 1'b1;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign convst_n_o = convst_q;
  assign cs_n_o     = cs_q;
  assign rd_n_o     = rd_q;
  assign err_o      = err_q;

  a_r6_cs_before_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_n_o) |-> $past(!cs_n_o));
  a_r6_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> $stable(addr_o));
  a_r6_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_n_o) |-> $rose(cs_n_o));
  a_r7_sample_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |-> (!cs_n_o && !rd_n_o));
  a_r5_pd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && mode_q && eoc_n_i) |-> !convst_n_o);
  a_r11_err_from_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(st_q == ST_WAIT) && convst_n_o && cs_n_o));
  a_r12_no_start_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(convst_n_o) |-> $past(!res_valid_o));
endmodule

// File: tb/adc_seq_bench.sv
`timescale 1ns/1ps
module adc_seq_bench;
  localparam int CONV_LOW = 4;
  localparam int ACQ      = 24;
  localparam int RD_LOW   = 3;
  localparam int TMO      = 40;
  localparam int EOC_DLY  = 6;

  // {pwrdn, scan, chan[2:0], data[7:0]}
  localparam logic [12:0] VECS [6] = '{
    {1'b0, 1'b0, 3'd5, 8'hA5},
    {1'b1, 1'b0, 3'd2, 8'h3C},
    {1'b0, 1'b1, 3'd0, 8'hFF},
    {1'b1, 1'b1, 3'd6, 8'h00},
    {1'b0, 1'b0, 3'd7, 8'h81},
    {1'b0, 1'b1, 3'd1, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, pwrdn_i = 1'b0, scan_i = 1'b0, eoc_n_i = 1'b1, res_ready_i = 1'b0;
  logic [2:0] chan_i = '0;
  logic [7:0] data_i = 8'h5A;
  logic convst_n_o, cs_n_o, rd_n_o, res_valid_o, err_o;
  logic [2:0] addr_o, res_chan_o;
  logic [7:0] res_data_o;

  int checks = 0, fails = 0, cyc = 0, prev_fall = 0;
  bit have_prev = 1'b0;
  logic [2:0] exp_cur = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq u_adc_seq (
    .clk_i(clk), .rst_ni, .req_i, .pwrdn_i, .scan_i, .chan_i,
    .convst_n_o, .eoc_n_i, .cs_n_o, .rd_n_o, .addr_o, .data_i,
    .res_valid_o, .res_ready_i, .res_data_o, .res_chan_o, .err_o);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wait_fall(input bit chk_start);
    int n = 0;
    do begin @(negedge clk); n++; end while (convst_n_o && n < 500);
    req_i = 1'b0;
    if (chk_start) chk(n == 1, "R2 start latency", n, 1);
    if (have_prev) chk(cyc - prev_fall >= ACQ, "R3 start spacing", cyc - prev_fall, ACQ);
    prev_fall = cyc;
    have_prev = 1'b1;
  endtask

  task automatic run_conv(input logic pd, input logic sc, input logic [2:0] ch,
                          input logic [7:0] val, input bit consume, input bit chk_start);
    logic [2:0] exp_addr;
    int lo, k;
    logic [7:0] held;
    exp_addr = sc ? exp_cur + 3'd1 : ch;
    data_i = ~val;
    @(negedge clk);
    req_i = 1'b1; pwrdn_i = pd; scan_i = sc; chan_i = ch;
    wait_fall(chk_start);
    chk(err_o == 1'b0, "R11 err cleared on start", err_o, 0);
    if (!pd) begin
      lo = 1;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (!convst_n_o) lo++; else break;
      end
      chk(lo == CONV_LOW, "R4 pulse width", lo, CONV_LOW);
      repeat (2) @(negedge clk);
    end else begin
      lo = 1;
      repeat (EOC_DLY) begin @(negedge clk); if (!convst_n_o) lo++; end
      chk(lo == EOC_DLY + 1, "R5 held low until eoc", lo, EOC_DLY + 1);
    end
    eoc_n_i = 1'b0;
    @(negedge clk);
    eoc_n_i = 1'b1;
    chk(convst_n_o == 1'b1, "R5 convst high after eoc", convst_n_o, 1);
    chk(!cs_n_o && rd_n_o, "R6 cs before rd", {cs_n_o, rd_n_o}, 1);
    chk(addr_o == exp_addr, "R8 next address", addr_o, exp_addr);
    k = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!cs_n_o && !rd_n_o) begin
        k++;
        chk(addr_o == exp_addr, "R6 address held", addr_o, exp_addr);
        data_i = (k < RD_LOW) ? val : ~val;
      end else break;
    end
    data_i = 8'h5A;
    chk(k == RD_LOW, "R6 read low width", k, RD_LOW);
    chk(cs_n_o == 1'b1, "R6 cs released with rd", cs_n_o, 1);
    chk(res_valid_o == 1'b1, "R10 valid on release", res_valid_o, 1);
    chk(res_data_o == val, "R7 captured byte", res_data_o, val);
    chk(res_chan_o == exp_cur, "R9 channel tag", res_chan_o, exp_cur);
    exp_cur = exp_addr;
    if (consume) begin
      held = res_data_o;
      repeat (3) begin
        @(negedge clk);
        chk(res_valid_o && res_data_o == held, "R10 hold while stalled", res_data_o, held);
      end
      res_ready_i = 1'b1;
      @(negedge clk);
      res_ready_i = 1'b0;
      chk(res_valid_o == 1'b0, "R10 valid drops after ready", res_valid_o, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(convst_n_o && cs_n_o && rd_n_o, "R1 strobes idle in reset",
        {convst_n_o, cs_n_o, rd_n_o}, 7);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(convst_n_o && cs_n_o && rd_n_o, "R1 strobes idle", {convst_n_o, cs_n_o, rd_n_o}, 7);
    chk(!res_valid_o && !err_o, "R1 flags low", {res_valid_o, err_o}, 0);
    chk(addr_o == 3'd0, "R1 address zero", addr_o, 0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      run_conv(VECS[v][12], VECS[v][11], VECS[v][10:8], VECS[v][7:0], 1'b1, v == 0);
    end

    // R8 scan wrap through 7 -> 0
    for (int s = 0; s < 9; s++) begin
      run_conv(1'b0, 1'b1, 3'd0, 8'(8'h10 + s), 1'b1, 1'b0);
    end

    // R11 timeout
    @(negedge clk);
    req_i = 1'b1; pwrdn_i = 1'b1; scan_i = 1'b0; chan_i = 3'd3;
    wait_fall(1'b0);
    begin
      int n = 0;
      while (!err_o && n < 200) begin
        @(negedge clk);
        n++;
        if (!cs_n_o) chk(1'b0, "R11 no read on timeout", cs_n_o, 1);
      end
      chk(n == TMO, "R11 timeout cycle", n, TMO);
      chk(convst_n_o == 1'b1, "R11 convst released", convst_n_o, 1);
      chk(res_valid_o == 1'b0, "R11 no result", res_valid_o, 0);
    end
    run_conv(1'b0, 1'b0, 3'd4, 8'hC3, 1'b1, 1'b0);

    // R12 pending result blocks a new start
    run_conv(1'b0, 1'b0, 3'd1, 8'h99, 1'b0, 1'b0);
    @(negedge clk);
    req_i = 1'b1; pwrdn_i = 1'b0; scan_i = 1'b0; chan_i = 3'd2;
    begin
      bit started = 1'b0;
      repeat (30) begin @(negedge clk); if (!convst_n_o) started = 1'b1; end
      chk(!started, "R12 no start while pending", started, 0);
      chk(res_data_o == 8'h99, "R12 result kept", res_data_o, 8'h99);
    end
    res_ready_i = 1'b1;
    @(negedge clk);
    res_ready_i = 1'b0;
    req_i = 1'b0;
    run_conv(1'b0, 1'b0, 3'd2, 8'h42, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule